// File: doc/BRIEF.md
# Mixed-Width Block RAM with Address Hold

The block is a synchronous simple dual-port memory with one write port and one read port on a single clock. The two ports may differ in width by a power-of-two ratio fixed at elaboration. Storage is kept as narrow sub-words. The narrower port addresses those sub-words directly. The wider port sees each group of sub-words as one word, with the lowest narrow address placed in the least significant bits.

Each port has an address hold input. While a hold input is high, the port ignores its address bus and keeps working on the address it captured last. This lets a write burst continue into one location, or a read keep returning one word, without the driver having to keep the bus steady. An optional output register adds a cycle of read latency. One clear input acts asynchronously on the read side only: the read-address register, the output latch and, when fitted, the output register. Clear is released on the clock through a short synchronizer. The write-side registers are never cleared.

Top module: `mixWidthRam`

## Requirements
- R1: With an 8-bit write port and a 16-bit read port, read word w returns byte 2w+1 in bits 15:8 and byte 2w in bits 7:0.
- R2: With a 16-bit write port and an 8-bit read port, read byte 2w returns bits 7:0 and read byte 2w+1 returns bits 15:8 of write word w.
- R3: With the output register off, rdData shows the word at the read address captured at a clock edge just after that same edge.
- R4: With the output register on, rdData shows the word at a captured read address after the second clock edge, and it still shows the previous word after the first.
- R5: While rdStall is high, the read port keeps the address it captured last and ignores rdAddr. When rdStall returns low, the next edge captures rdAddr again.
- R6: While wrStall is high, writes with wrEn high go to the write address captured last, and wrAddr is ignored.
- R7: A read and a write of the same storage in the same edge return the data stored before the write. The new data is returned on the next read.
- R8: Raising aclr forces rdData to zero at once, with no clock edge, with or without the output register. rdData stays zero while aclr is high.
- R9: Clear resets the read-address register to address zero. After clear, a held read port reads address 0 whatever rdAddr carries.
- R10: Clear leaves the write side alone. The captured write address survives it, and writes issued while aclr is high still land in memory.
- R11: Clear is released on the clock. rdData stays zero through the first two clock edges after aclr falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| aclr | input | 1 | Read-side clear: asserts asynchronously, released through a clocked synchronizer |
| wrEn | input | 1 | Write enable, sampled at the clock edge |
| wrStall | input | 1 | Write address hold; high keeps the last captured write address |
| wrAddr | input | WR_AW | Write address in write-port words |
| wrData | input | WR_W | Write data |
| rdStall | input | 1 | Read address hold; high keeps the last captured read address |
| rdAddr | input | RD_AW | Read address in read-port words |
| rdData | output | RD_W | Read data, from the output latch or from the optional output register |

## Verification
The bench sweeps every location of two small configurations, narrow-to-wide without an output register and wide-to-narrow with one. A design that swapped the sub-word order, or that had one cycle too many or too few of latency, would return the neighbour's data or stale data throughout the sweep. Directed cases then aim at the hold inputs. A design that let a held write follow the bus would corrupt an untouched location, and a design that let a held read follow the bus would return the new word early. The clear case checks the read output at once, between edges, and at the first two edges after release. It also checks that the read address went to zero while the write address kept its captured value. A design that cleared only on an edge, released clear at once, or reset the write registers would fail there. A write and a read to the same word on one edge tell read-before-write apart from write-through.

// File: rtl/mixRamPkg.sv
`timescale 1ns/1ps
package mixRamPkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic doWrite;   // commit a write at this edge
    logic holdRead;  // read address is being held
    logic clearNow;  // read-side clear, asynchronous assertion
  } ramStrobes_t;

endpackage

// File: rtl/mixRamCtrl.sv
`timescale 1ns/1ps
module mixRamCtrl
  import mixRamPkg::*;
#(
  parameter int WR_AW      = 6,
  parameter int RD_AW      = 5,
  parameter int CLR_STAGES = 2
) (
  input  logic             clk,
  input  logic             aclr,
  input  logic             wrEn,
  input  logic             wrStall,
  input  logic [WR_AW-1:0] wrAddr,
  input  logic             rdStall,
  input  logic [RD_AW-1:0] rdAddr,
  output logic [WR_AW-1:0] wrAddrEff,
  output logic [RD_AW-1:0] rdAddrEff,
  output ramStrobes_t      strobes
);

  logic [CLR_STAGES-1:0] clrPipe;
  logic [WR_AW-1:0]      wrAddrReg;
  logic [RD_AW-1:0]      rdAddrReg;
  logic                  clearNow;

  // Asynchronous assertion, release shifted out on the clock
  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) clrPipe <= '1;
    else      clrPipe <= {clrPipe[CLR_STAGES-2:0], 1'b0};
  end

  assign clearNow = aclr | clrPipe[CLR_STAGES-1];

  // Address used at the coming edge: held register or live bus
  assign wrAddrEff = wrStall ? wrAddrReg : wrAddr;
  assign rdAddrEff = rdStall ? rdAddrReg : rdAddr;

  // Write address register: never cleared
  always_ff @(posedge clk) begin
    wrAddrReg <= wrAddrEff;
  end

  // Read address register: cleared with the read side
  always_ff @(posedge clk or posedge clearNow) begin
    if (clearNow) rdAddrReg <= '0;
    else          rdAddrReg <= rdAddrEff;
  end

  always_comb begin
    strobes.doWrite  = wrEn;
    strobes.holdRead = rdStall;
    strobes.clearNow = clearNow;
  end

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (aclr)
    wrStall |-> wrAddrEff == $past(wrAddrEff));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (clearNow)
    (rdStall && !$past(clearNow)) |-> rdAddrEff == $past(rdAddrEff));

  // R9
  rd_clr_addr_chk: assert property (@(posedge clk) disable iff (clearNow)
    (rdStall && $past(clearNow)) |-> rdAddrEff == '0);

endmodule

// File: rtl/mixRamData.sv
`timescale 1ns/1ps
module mixRamData
  import mixRamPkg::*;
#(
  parameter int WR_W    = 8,
  parameter int RD_W    = 16,
  parameter int WR_AW   = 6,
  parameter int RD_AW   = 5,
  parameter bit OUT_REG = 1'b0
) (
  input  logic             clk,
  input  ramStrobes_t      strobes,
  input  logic [WR_AW-1:0] wrAddrEff,
  input  logic [WR_W-1:0]  wrData,
  input  logic [RD_AW-1:0] rdAddrEff,
  output logic [RD_W-1:0]  rdData
);

  localparam int NARROW_W = (WR_W < RD_W) ? WR_W : RD_W;
  localparam int WR_LANES = WR_W / NARROW_W;
  localparam int RD_LANES = RD_W / NARROW_W;
  localparam int DEPTH    = (1 << WR_AW) * WR_LANES;
  localparam int NAW      = $clog2(DEPTH);

  logic [NARROW_W-1:0] mem [DEPTH];
  logic [RD_W-1:0]     rdWord;
  logic [RD_W-1:0]     rdLatch;
  logic                clr;
  logic [1:0]          quietCnt;

  assign clr = strobes.clearNow;

  // Sub-word store, lowest narrow address in the low lane
  always_ff @(posedge clk) begin
    if (strobes.doWrite) begin
      for (int l = 0; l < WR_LANES; l++) begin
        mem[NAW'(int'(wrAddrEff) * WR_LANES + l)] <= wrData[l*NARROW_W +: NARROW_W];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < RD_LANES; l++) begin
      rdWord[l*NARROW_W +: NARROW_W] = mem[NAW'(int'(rdAddrEff) * RD_LANES + l)];
    end
  end

  // Output latch: samples the pre-write contents (read-before-write)
  always_ff @(posedge clk or posedge clr) begin
    if (clr) rdLatch <= '0;
    else     rdLatch <= rdWord;
  end

  generate
    if (OUT_REG) begin : g_outReg
      logic [RD_W-1:0] outReg;
      always_ff @(posedge clk or posedge clr) begin
        if (clr) outReg <= '0;
        else     outReg <= rdLatch;
      end
      assign rdData = outReg;
    end else begin : g_noOutReg
      assign rdData = rdLatch;
    end
  endgenerate

  // Edges in a row with the read address held and no write
  always_ff @(posedge clk or posedge clr) begin
    if (clr)                                        quietCnt <= '0;
    else if (strobes.holdRead && !strobes.doWrite) quietCnt <= (quietCnt == 2'd3) ? quietCnt : quietCnt + 2'd1;
    else                                            quietCnt <= '0;
  end

  // R8
  clr_out_zero_chk: assert property (@(posedge clk)
    clr |-> rdData == '0);

  // R5
  held_read_stable_chk: assert property (@(posedge clk) disable iff (clr)
    (quietCnt == 2'd3) |-> $stable(rdData));

endmodule

// File: rtl/mixWidthRam.sv
`timescale 1ns/1ps
module mixWidthRam
  import mixRamPkg::*;
#(
  parameter int WR_W       = 8,
  parameter int RD_W       = 16,
  parameter int WR_AW      = 6,
  parameter bit OUT_REG    = 1'b0,
  parameter int CLR_STAGES = 2,
  localparam int WIDE_W    = (WR_W > RD_W) ? WR_W : RD_W,
  localparam int NARR_W    = (WR_W < RD_W) ? WR_W : RD_W,
  localparam int LOG_R     = $clog2(WIDE_W / NARR_W),
  localparam int RD_AW     = (WR_W <= RD_W) ? (WR_AW - LOG_R) : (WR_AW + LOG_R)
) (
  input  logic             clk,
  input  logic             aclr,
  input  logic             wrEn,
  input  logic             wrStall,
  input  logic [WR_AW-1:0] wrAddr,
  input  logic [WR_W-1:0]  wrData,
  input  logic             rdStall,
  input  logic [RD_AW-1:0] rdAddr,
  output logic [RD_W-1:0]  rdData
);

  ramStrobes_t      strobes;
  logic [WR_AW-1:0] wrAddrEff;
  logic [RD_AW-1:0] rdAddrEff;

  mixRamCtrl #(
    .WR_AW(WR_AW), .RD_AW(RD_AW), .CLR_STAGES(CLR_STAGES)
  ) i_ctrl (
    .clk(clk), .aclr(aclr), .wrEn(wrEn), .wrStall(wrStall), .wrAddr(wrAddr),
    .rdStall(rdStall), .rdAddr(rdAddr), .wrAddrEff(wrAddrEff),
    .rdAddrEff(rdAddrEff), .strobes(strobes)
  );

  mixRamData #(
    .WR_W(WR_W), .RD_W(RD_W), .WR_AW(WR_AW), .RD_AW(RD_AW), .OUT_REG(OUT_REG)
  ) i_data (
    .clk(clk), .strobes(strobes), .wrAddrEff(wrAddrEff), .wrData(wrData),
    .rdAddrEff(rdAddrEff), .rdData(rdData)
  );

endmodule

// File: tb/test_mixWidthRam.sv
`timescale 1ns/1ps
module test_mixWidthRam;

  logic clk = 1'b0;
  logic aclr = 1'b1;
  always #2.5 clk = ~clk;

  // DUT A: 8-bit write, 16-bit read, no output register
  logic        wrEnA = 0, wrStallA = 0, rdStallA = 0;
  logic [5:0]  wrAddrA = '0;
  logic [7:0]  wrDataA = '0;
  logic [4:0]  rdAddrA = '0;
  logic [15:0] rdDataA;

  // DUT B: 16-bit write, 8-bit read, output register
  logic        wrEnB = 0, wrStallB = 0, rdStallB = 0;
  logic [4:0]  wrAddrB = '0;
  logic [15:0] wrDataB = '0;
  logic [5:0]  rdAddrB = '0;
  logic [7:0]  rdDataB;

  int total = 0;
  int bad   = 0;

  mixWidthRam #(.WR_W(8), .RD_W(16), .WR_AW(6), .OUT_REG(1'b0)) i_mixWidthRam (
    .clk(clk), .aclr(aclr), .wrEn(wrEnA), .wrStall(wrStallA), .wrAddr(wrAddrA),
    .wrData(wrDataA), .rdStall(rdStallA), .rdAddr(rdAddrA), .rdData(rdDataA));

  mixWidthRam #(.WR_W(16), .RD_W(8), .WR_AW(5), .OUT_REG(1'b1)) i_mixWidthRam_b (
    .clk(clk), .aclr(aclr), .wrEn(wrEnB), .wrStall(wrStallB), .wrAddr(wrAddrB),
    .wrData(wrDataB), .rdStall(rdStallB), .rdAddr(rdAddrB), .rdData(rdDataB));

  function automatic logic [7:0] pat(int n, int s);
    return 8'((n * 37 + s) & 255);
  endfunction

  function automatic logic [15:0] wordA(int w);
    return {pat(2*w+1, 0), pat(2*w, 0)};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    #1;
    // R8 reset state: clear is high from time zero
    chk("R8 reset A", rdDataA, 16'h0);
    chk("R8 reset B", {8'h0, rdDataB}, 16'h0);
    repeat (3) @(negedge clk);
    aclr = 1'b0;
    repeat (4) @(negedge clk);

    // Fill A byte by byte
    for (int n = 0; n < 64; n++) begin
      wrEnA = 1; wrAddrA = 6'(n); wrDataA = pat(n, 0);
      @(negedge clk);
    end
    wrEnA = 0;

    // R1 / R3: sweep every read word, one clock of latency
    for (int w = 0; w < 32; w++) begin
      @(negedge clk) rdAddrA = 5'(w);
      @(posedge clk); #1;
      chk("R1/R3 sweep A", rdDataA, wordA(w));
    end

    // R5: held read address ignores the bus
    @(negedge clk) rdAddrA = 5'd3;
    @(negedge clk) begin rdStallA = 1; rdAddrA = 5'd9; end
    @(posedge clk); #1; chk("R5 hold A edge1", rdDataA, wordA(3));
    @(posedge clk); #1; chk("R5 hold A edge2", rdDataA, wordA(3));
    @(negedge clk) rdStallA = 0;
    @(posedge clk); #1; chk("R5 release A", rdDataA, wordA(9));

    // R6: held write address receives the second write
    @(negedge clk) begin wrEnA = 1; wrAddrA = 6'd10; wrDataA = 8'hA5; end
    @(negedge clk) begin wrStallA = 1; wrAddrA = 6'd40; wrDataA = 8'h5A; end
    @(negedge clk) begin wrEnA = 0; wrStallA = 0; rdAddrA = 5'd5; end
    @(posedge clk); #1; chk("R6 held write lands", rdDataA, {pat(11, 0), 8'h5A});
    @(negedge clk) rdAddrA = 5'd20;
    @(posedge clk); #1; chk("R6 bus address untouched", rdDataA, wordA(20));

    // R7: read-before-write on the same word
    @(negedge clk) begin rdAddrA = 5'd7; wrEnA = 1; wrAddrA = 6'd14; wrDataA = 8'hC3; end
    @(posedge clk); #1; chk("R7 old data", rdDataA, wordA(7));
    @(negedge clk) wrEnA = 0;
    @(posedge clk); #1; chk("R7 new data", rdDataA, {pat(15, 0), 8'hC3});

    // Fill B word by word
    for (int w = 0; w < 32; w++) begin
      @(negedge clk) begin wrEnB = 1; wrAddrB = 5'(w); wrDataB = {pat(2*w+1, 77), pat(2*w, 77)}; end
    end
    @(negedge clk) wrEnB = 0;

    // R2: sweep every read byte of B
    for (int n = 0; n < 64; n++) begin
      @(negedge clk) rdAddrB = 6'(n);
      @(posedge clk); @(posedge clk); #1;
      chk("R2 sweep B", {8'h0, rdDataB}, {8'h0, pat(n, 77)});
    end

    // R4: two clocks of latency with the output register
    @(negedge clk) rdAddrB = 6'd5;
    @(posedge clk); #1; chk("R4 first edge old", {8'h0, rdDataB}, {8'h0, pat(63, 77)});
    @(posedge clk); #1; chk("R4 second edge new", {8'h0, rdDataB}, {8'h0, pat(5, 77)});

    // Clear sequence on both instances
    @(negedge clk) begin wrAddrA = 6'd50; wrStallA = 0; rdAddrA = 5'd12; rdStallA = 0; end
    @(negedge clk) begin wrStallA = 1; wrAddrA = 6'd2; rdStallA = 1; end
    #1;
    chk("R8 pre-clear A nonzero", {15'h0, rdDataA != 16'h0}, 16'h1);
    aclr = 1'b1;
    #1;
    chk("R8 immediate A", rdDataA, 16'h0);
    chk("R8 immediate B", {8'h0, rdDataB}, 16'h0);
    @(negedge clk) begin wrEnA = 1; wrDataA = 8'h99; end
    @(negedge clk) wrEnA = 0;
    chk("R8 held A", rdDataA, 16'h0);
    aclr = 1'b0;
    @(posedge clk); #1; chk("R11 edge1 A", rdDataA, 16'h0);
    @(posedge clk); #1; chk("R11 edge2 A", rdDataA, 16'h0);
    chk("R11 edge2 B", {8'h0, rdDataB}, 16'h0);

    // R9: read address register went to zero; rewrite word 0 and read it held
    @(negedge clk) begin wrStallA = 0; wrEnA = 1; wrAddrA = 6'd0; wrDataA = 8'h11; end
    @(negedge clk) begin wrAddrA = 6'd1; wrDataA = 8'h22; end
    @(negedge clk) wrEnA = 0;
    @(posedge clk); #1; chk("R9 held read at zero", rdDataA, 16'h2211);

    // R10: write issued during clear used the captured address 50
    @(negedge clk) begin rdStallA = 0; rdAddrA = 5'd25; end
    @(posedge clk); #1; chk("R10 write during clear", {8'h0, rdDataA[7:0]}, 16'h0099);

    finishRun();
  end

endmodule